// File: doc/BRIEF.md
# Blockwise Kleene-Star Marker Unit

This unit produces marker streams for bit-parallel pattern matching, handling a block of `BLK_W` text positions per beat. Bit 0 of every block is the earliest text position of that block. A 1 in a marker stream marks the next position still to be matched, which is the position just after the last character consumed. Each accepted beat yields two registered results from the same marker stream `mark_in` and class stream `cls_in`.

The star result is `((mark & cls) + cls) ^ cls | mark`. It marks every position reachable from a marker by zero or more characters of the class. The step result is `mark & cls` moved one position later in the text. It consumes exactly one class character and is used to chain classes in a pattern. The addition carry and the bit shifted out of the last position are both kept between beats, so a stream split into blocks gives the same result as one unbounded computation. For the pattern `a[0-9]*z`, the three passes are step(all-ones, [a]), then star(previous, [0-9]), then step(previous, [z]).

A small controller has two states. `ST_IDLE` is entered on reset, and beats are ignored there. `ST_ACTIVE` is entered from either state whenever `clr` is high, and the unit stays there until the next reset. `clr` marks the start of a stream and zeroes both carries. A beat that arrives together with `clr` is the first beat of the new stream and sees zero carries.

Top module: `msu_marker_unit`

## Requirements
- R1: After reset, `res_vld` is 0 and `star_res` and `step_res` are all zeros.
- R2: Before the first `clr` following reset, a beat with `beat_vld` high is ignored and gives no `res_vld` pulse.
- R3: An accepted beat makes `res_vld` high in the next cycle. `star_res` then marks position p when some marker q ≤ p exists and every position q..p-1 is in the class, with class runs followed across earlier beats of the same stream.
- R4: Every set bit of `mark_in` in an accepted beat is also set in the resulting `star_res`.
- R5: A class run that reaches the last position of a block carries its reach into position 0 and onward in the next accepted beat of the same stream.
- R6: `step_res` bit p equals `mark_in[p-1] & cls_in[p-1]` for p ≥ 1. Bit 0 equals `mark_in[BLK_W-1] & cls_in[BLK_W-1]` of the previous accepted beat of the stream, or 0 on the first beat.
- R7: `clr` zeroes both carries, and a beat that arrives together with `clr` is computed with zero carries.
- R8: Cycles with `beat_vld` low give `res_vld` low and leave both carries unchanged for the next beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Stream start: zero the carries and enter ST_ACTIVE |
| beat_vld | input | 1 | A block is present on `mark_in` and `cls_in` |
| mark_in | input | BLK_W | Marker stream block, bit 0 earliest |
| cls_in | input | BLK_W | Character-class stream block |
| res_vld | output | 1 | Results hold a new block |
| star_res | output | BLK_W | Star closure of `mark_in` through `cls_in` |
| step_res | output | BLK_W | One-position advance of `mark_in & cls_in` |

## Verification
A wrong addition carry shows only at the start of the next beat. The low bits of `star_res` are then either missing or extra along a class run that reaches past the block edge. A stale shift bit shows in `step_res` bit 0 of the following beat. A carry that `clr` fails to zero corrupts the first beat of the new stream, so the stimulus places long class runs right before clears and across block edges.

// File: rtl/msu_pkg.sv
package msu_pkg;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } msu_state_e;

endpackage

// File: rtl/msu_ctrl.sv
module msu_ctrl
    import msu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       beat_vld,
    output msu_state_e state,
    output logic       accept
);

    msu_state_e state_q;
    msu_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (clr) state_d = ST_ACTIVE;
                accept = clr & beat_vld;
            end
            ST_ACTIVE: begin
                state_d = ST_ACTIVE;
                accept  = beat_vld;
            end
            default: begin
                state_d = ST_IDLE;
                accept  = 1'b0;
            end
        endcase
    end

    assign state = state_q;

    // R7: a clear always leaves the controller active
    a_r7_clear_activates: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (state_q == ST_ACTIVE));

endmodule

// File: rtl/msu_lane_adder.sv
module msu_lane_adder #(
    parameter int W      = 32,
    parameter int LANE_W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);

    localparam int LANES = W / LANE_W;

    logic [LANES:0] chain;

    assign chain[0] = cin;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign {chain[g+1], sum[g*LANE_W +: LANE_W]} =
              {1'b0, a[g*LANE_W +: LANE_W]}
            + {1'b0, b[g*LANE_W +: LANE_W]}
            + {{LANE_W{1'b0}}, chain[g]};
    end

    assign cout = chain[LANES];

endmodule

// File: rtl/msu_shifter.sv
module msu_shifter #(
    parameter int W = 32
) (
    input  logic [W-1:0] din,
    input  logic         sin,
    output logic [W-1:0] dout,
    output logic         sout
);

    assign dout = {din[W-2:0], sin};
    assign sout = din[W-1];

endmodule

// File: rtl/msu_marker_unit.sv
module msu_marker_unit
    import msu_pkg::*;
#(
    parameter int BLK_W  = 32,
    parameter int LANE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             beat_vld,
    input  logic [BLK_W-1:0] mark_in,
    input  logic [BLK_W-1:0] cls_in,
    output logic             res_vld,
    output logic [BLK_W-1:0] star_res,
    output logic [BLK_W-1:0] step_res
);

    msu_state_e       ctl_state;
    logic             accept;
    logic             carry_q;
    logic             shin_q;
    logic             carry_in;
    logic             shift_in;
    logic [BLK_W-1:0] masked;
    logic [BLK_W-1:0] sum;
    logic             sum_cout;
    logic [BLK_W-1:0] shifted;
    logic             shift_out;
    logic [BLK_W-1:0] star_d;

    msu_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .beat_vld (beat_vld),
        .state    (ctl_state),
        .accept   (accept)
    );

    assign masked   = mark_in & cls_in;
    assign carry_in = clr ? 1'b0 : carry_q;
    assign shift_in = clr ? 1'b0 : shin_q;

    msu_lane_adder #(.W(BLK_W), .LANE_W(LANE_W)) u_add (
        .a    (masked),
        .b    (cls_in),
        .cin  (carry_in),
        .sum  (sum),
        .cout (sum_cout)
    );

    msu_shifter #(.W(BLK_W)) u_shift (
        .din  (masked),
        .sin  (shift_in),
        .dout (shifted),
        .sout (shift_out)
    );

    assign star_d = (sum ^ cls_in) | mark_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_vld  <= 1'b0;
            star_res <= '0;
            step_res <= '0;
            carry_q  <= 1'b0;
            shin_q   <= 1'b0;
        end else begin
            res_vld <= accept;
            if (accept) begin
                star_res <= star_d;
                step_res <= shifted;
                carry_q  <= sum_cout;
                shin_q   <= shift_out;
            end else if (clr) begin
                carry_q  <= 1'b0;
                shin_q   <= 1'b0;
            end
        end
    end

    // R2: no result while idle without a clear
    a_r2_idle_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_state == ST_IDLE && !clr) |=> !res_vld);

    // R3: a result only follows a presented beat
    a_r3_result_follows_beat: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> $past(beat_vld));

    // R4: star result covers every input marker
    a_r4_keeps_markers: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ((star_res & $past(mark_in)) == $past(mark_in)));

    // R6: upper step bits are the masked markers moved one place later
    a_r6_step_shift: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (step_res[BLK_W-1:1] == $past(mark_in[BLK_W-2:0] & cls_in[BLK_W-2:0])));

    // R7: a clear without a beat leaves both carries at zero
    a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !beat_vld) |=> (!carry_q && !shin_q));

    // R8: carries hold across cycles with no beat and no clear
    a_r8_carry_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept && !clr) |=> ($stable(carry_q) && $stable(shin_q)));

endmodule

// File: tb/msu_marker_unit_tb.sv
`timescale 1ns/1ps
module msu_marker_unit_tb_top;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clr = 1'b0;
    logic         beat_vld = 1'b0;
    logic [W-1:0] mark_in = '0;
    logic [W-1:0] cls_in = '0;
    logic         res_vld;
    logic [W-1:0] star_res;
    logic [W-1:0] step_res;

    int n_chk = 0;
    int n_bad = 0;

    logic m_act = 1'b0;
    logic m_reach = 1'b0;
    logic m_adv = 1'b0;
    logic [W-1:0] got_star;
    logic [W-1:0] got_step;

    always #2 clk = ~clk;

    msu_marker_unit #(.BLK_W(W), .LANE_W(8)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .beat_vld (beat_vld),
        .mark_in  (mark_in),
        .cls_in   (cls_in),
        .res_vld  (res_vld),
        .star_res (star_res),
        .step_res (step_res)
    );

    task automatic check(input string tag, input logic ok,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called at a falling edge; checks at the next falling edge
    task automatic beat(input logic c, input logic v, input logic [W-1:0] m,
                        input logic [W-1:0] k, input string tag);
        logic go;
        logic prev;
        logic r;
        logic [W-1:0] es;
        logic [W-1:0] ep;
        clr = c; beat_vld = v; mark_in = m; cls_in = k;
        if (c) begin m_act = 1'b1; m_reach = 1'b0; m_adv = 1'b0; end
        go = v && m_act;
        es = '0; ep = '0;
        if (go) begin
            prev = m_reach;
            for (int p = 0; p < W; p++) begin
                r = m[p] | prev;
                es[p] = r;
                prev = r & k[p];
            end
            m_reach = prev;
            ep[0] = m_adv;
            for (int p = 1; p < W; p++) ep[p] = m[p-1] & k[p-1];
            m_adv = m[W-1] & k[W-1];
        end
        @(negedge clk);
        clr = 1'b0; beat_vld = 1'b0;
        check({tag, " vld"}, res_vld == go, {31'd0, res_vld}, {31'd0, go});
        if (go) begin
            check({tag, " star"}, star_res == es, star_res, es);
            check({tag, " step"}, step_res == ep, step_res, ep);
            check("R4 markers kept", (star_res & m) == m, star_res, m);
        end
        got_star = star_res;
        got_step = step_res;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check("R8 no result when idle", res_vld == 1'b0, {31'd0, res_vld}, '0);
        end
    endtask

    initial begin : watchdog
        #(4 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        string txt;
        logic [W-1:0] ca [2];
        logic [W-1:0] cd [2];
        logic [W-1:0] cz [2];
        logic [W-1:0] m1 [2];
        logic [W-1:0] m2 [2];
        logic [W-1:0] m3 [2];
        logic [W-1:0] rm;
        logic [W-1:0] rk;
        int sel;

        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset vld", res_vld == 1'b0, {31'd0, res_vld}, '0);
        check("R1 reset star", star_res == '0, star_res, '0);
        check("R1 reset step", step_res == '0, step_res, '0);

        beat(1'b0, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 ignored before clear");
        beat(1'b1, 1'b0, '0, '0, "R7 clear alone");

        // directed text pattern, two blocks
        txt = "a4534q--b29z---az---a4q--bca22z--";
        for (int b = 0; b < 2; b++) begin
            ca[b] = '0; cd[b] = '0; cz[b] = '0;
            for (int p = 0; p < W; p++) begin
                int idx;
                byte ch;
                idx = b * W + p;
                ch = (idx < txt.len()) ? txt[idx] : 8'h2D;
                ca[b][p] = (ch == 8'h61);
                cz[b][p] = (ch == 8'h7A);
                cd[b][p] = (ch >= 8'h30 && ch <= 8'h39);
            end
        end
        beat(1'b1, 1'b1, '1, ca[0], "R6 text step a");   m1[0] = got_step;
        beat(1'b0, 1'b1, '1, ca[1], "R6 text step a");   m1[1] = got_step;
        beat(1'b1, 1'b1, m1[0], cd[0], "R3 text star digits"); m2[0] = got_star;
        beat(1'b0, 1'b1, m1[1], cd[1], "R3 text star digits"); m2[1] = got_star;
        beat(1'b1, 1'b1, m2[0], cz[0], "R6 text step z"); m3[0] = got_step;
        beat(1'b0, 1'b1, m2[1], cz[1], "R6 text step z"); m3[1] = got_step;
        check("R3 text final block0", m3[0] == 32'h8002_0000, m3[0], 32'h8002_0000);
        check("R3 text final block1", m3[1] == '0, m3[1], '0);

        // run crossing a block edge, with idle gap between
        beat(1'b1, 1'b1, 32'h0000_0001, '1, "R5 run start");
        idle(3);
        beat(1'b0, 1'b1, '0, 32'h0000_00FF, "R5 R8 run continues after idle");
        check("R5 carried reach", got_star == 32'h0000_01FF, got_star, 32'h0000_01FF);
        // shift bit across edge
        beat(1'b1, 1'b1, 32'h8000_0000, 32'h8000_0000, "R6 edge bit");
        beat(1'b0, 1'b1, '0, '0, "R6 edge bit arrives");
        check("R6 bit0 from prior beat", got_step == 32'h1, got_step, 32'h1);
        // clear with beat kills pending carry
        beat(1'b1, 1'b1, 32'h1, '1, "R7 pending carry");
        beat(1'b1, 1'b1, '0, '1, "R7 clear with beat");
        check("R7 no carried reach", got_star == '0, got_star, '0);
        check("R7 no shifted bit", got_step == '0, got_step, '0);

        // random mix
        for (int i = 0; i < 400; i++) begin
            sel = $urandom % 16;
            if (sel == 0) idle(1 + $urandom % 3);
            rm = $urandom & $urandom & $urandom;
            if (sel < 4) rk = '1;
            else rk = $urandom | $urandom | $urandom;
            beat(sel == 1, 1'b1, rm, rk, "R3 R5 R6 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule